// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block sequences the operating modes of a microcontroller clock and reset generator. It moves between Run, Wait, Full Stop, Pseudo Stop and a degraded Self Clock mode. It responds to wait and stop requests, wake-up events and a clock monitor. From the current mode and a small set of control bits, it drives the oscillator enable, PLL enable, system and core clock gates, and the run enables of the watchdog and the periodic timer.

A selection bit picks one of two stop variants. Full Stop shuts the oscillator down and freezes everything. When it wakes, it holds the clocks gated until the oscillator reports itself stable. Pseudo Stop keeps the oscillator alive, and each timer can keep running through its own stop-mode enable bit. When the clock monitor reports a lost clock, the controller does one of two things, depending on the self-clock enable. It either enters Self Clock mode, where a clock quality check runs until it passes, or it raises a one-cycle loss-of-clock reset request.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset the controller is in Run, with oscillator, PLL, system clock and core clock all enabled. In Run, `wdog_run` is 1 exactly when `wdog_rate` is non-zero, and `ptim_run` is 1 exactly when `ptim_rate` is non-zero.
- R2: A `wait_req` seen in Run enters Wait at the next edge. In Wait, the oscillator and system clock stay on and the core clock is gated. `pll_en` is the inverse of `pll_wait_off`. The timers follow the Run rule of R1.
- R3: A `stop_req` seen in Run enters Full Stop at the next edge when `pstop_sel` is 0, and Pseudo Stop when it is 1. A stop request takes priority over a simultaneous wait request.
- R4: Whenever the oscillator enable is 0, the system clock, core clock, PLL and both timers are off. Full Stop drives all of these outputs to 0.
- R5: In Pseudo Stop, the oscillator stays on, and PLL, system clock and core clock are off. `wdog_run` is 1 exactly when `wdog_stop_en` is 1 and `wdog_rate` is non-zero. `ptim_run` follows the same rule with `ptim_stop_en` and `ptim_rate`.
- R6: Self Clock mode is entered from Run only when `cmon_en`, `self_en` and `clk_lost` are all 1 at a clock edge. If any one of them is 0, the controller stays out of Self Clock mode.
- R7: In Self Clock mode, `self_clk_active` and `qual_chk_en` are 1, `pll_en` is 0, and the system and core clocks run. The mode persists for as long as `qual_ok` is 0.
- R8: When `qual_ok` is 1 in Self Clock mode, the next edge returns to Run. `self_clk_active` clears and `pll_en` returns to 1.
- R9: If `cmon_en` is 1 and `self_en` is 0, the first edge at which `clk_lost` is seen asserts `loc_rst_req` for exactly one cycle. A lost clock that persists raises no further pulse.
- R10: A `wake_evt` in Wait or Pseudo Stop returns to Run at the next edge. In Full Stop, a wake event enables the oscillator but keeps the clocks gated until an edge at which `osc_stable` is 1. That edge returns to Run.
- R11: Wait and stop requests made during Self Clock mode have no effect. The mode and its outputs are unchanged until the quality check passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | Request to enter Wait |
| stop_req | input | 1 | Request to enter a stop mode |
| wake_evt | input | 1 | Wake-up event |
| osc_stable | input | 1 | Oscillator reports stable output |
| pll_wait_off | input | 1 | Turn PLL off while in Wait |
| pstop_sel | input | 1 | 1 selects Pseudo Stop, 0 Full Stop |
| cmon_en | input | 1 | Clock monitor enable |
| self_en | input | 1 | Self Clock mode enable |
| clk_lost | input | 1 | Clock monitor reports loss of clock |
| qual_ok | input | 1 | Clock quality check passed |
| wdog_rate | input | WDOG_RW | Watchdog rate select, 0 = off |
| ptim_rate | input | PTIM_RW | Periodic timer rate select, 0 = off |
| wdog_stop_en | input | 1 | Keep watchdog running in Pseudo Stop |
| ptim_stop_en | input | 1 | Keep periodic timer running in Pseudo Stop |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| sys_clk_en | output | 1 | System clock gate |
| core_clk_en | output | 1 | Core clock gate |
| wdog_run | output | 1 | Watchdog counter run enable |
| ptim_run | output | 1 | Periodic timer run enable |
| self_clk_active | output | 1 | Self Clock mode active |
| qual_chk_en | output | 1 | Clock quality check running |
| loc_rst_req | output | 1 | Loss-of-clock reset request pulse |

## Verification
Several properties hold on every cycle and are checked that way: the quiet outputs whenever the oscillator is off, the entry condition and persistence of Self Clock mode, its exit into Run with the PLL back on, the single-cycle width of the reset request, and timers that only run when their rate field is non-zero. Other behaviour needs scenarios that the bench drives: the choice between the two stop variants, the per-timer enables in Pseudo Stop, the wait-for-stable phase of a Full Stop wake-up, and the fact that requests made in Self Clock mode are dropped. The bench also sweeps every rate value and every combination of the stop-mode enables.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_WAIT  = 3'd1,
    M_FSTOP = 3'd2,
    M_FWAKE = 3'd3,
    M_PSTOP = 3'd4,
    M_SELF  = 3'd5
  } pm_mode_t;

  typedef struct packed {
    logic osc;
    logic pll;
    logic sys;
    logic core;
    logic wdog;
    logic ptim;
    logic self_act;
    logic qchk;
  } pm_out_t;

  // A rate field enables its timer when any bit is set.
  function automatic logic rate_active(input logic [15:0] rate);
    return rate != 16'd0;
  endfunction

endpackage

// File: rtl/clkpm_next.sv
module clkpm_next
  import clkpm_pkg::*;
(
  input  pm_mode_t mode,
  input  logic     wait_req,
  input  logic     stop_req,
  input  logic     wake_evt,
  input  logic     osc_stable,
  input  logic     pstop_sel,
  input  logic     self_go,
  input  logic     qual_ok,
  output pm_mode_t nxt
);

  always_comb begin
    nxt = mode;
    unique case (mode)
      M_RUN: begin
        if (self_go)       nxt = M_SELF;
        else if (stop_req) nxt = pstop_sel ? M_PSTOP : M_FSTOP;
        else if (wait_req) nxt = M_WAIT;
      end
      M_WAIT:  if (wake_evt)   nxt = M_RUN;
      M_FSTOP: if (wake_evt)   nxt = M_FWAKE;
      M_FWAKE: if (osc_stable) nxt = M_RUN;
      M_PSTOP: if (wake_evt)   nxt = M_RUN;
      M_SELF:  if (qual_ok)    nxt = M_RUN;
      default: nxt = M_RUN;
    endcase
  end

endmodule

// File: rtl/clkpm_decode.sv
module clkpm_decode
  import clkpm_pkg::*;
(
  input  pm_mode_t mode,
  input  logic     pll_wait_off,
  input  logic     wdog_on,
  input  logic     ptim_on,
  input  logic     wdog_stop_en,
  input  logic     ptim_stop_en,
  output pm_out_t  o
);

  always_comb begin
    o = '0;
    unique case (mode)
      M_RUN: begin
        o.osc = 1'b1; o.pll = 1'b1; o.sys = 1'b1; o.core = 1'b1;
        o.wdog = wdog_on; o.ptim = ptim_on;
      end
      M_WAIT: begin
        o.osc = 1'b1; o.pll = ~pll_wait_off; o.sys = 1'b1;
        o.wdog = wdog_on; o.ptim = ptim_on;
      end
      M_FSTOP: o = '0;
      M_FWAKE: o.osc = 1'b1;
      M_PSTOP: begin
        o.osc  = 1'b1;
        o.wdog = wdog_on & wdog_stop_en;
        o.ptim = ptim_on & ptim_stop_en;
      end
      M_SELF: begin
        o.osc = 1'b1; o.sys = 1'b1; o.core = 1'b1;
        o.wdog = wdog_on; o.ptim = ptim_on;
        o.self_act = 1'b1; o.qchk = 1'b1;
      end
      default: o = '0;
    endcase
  end

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int WDOG_RW = 3,
  parameter int PTIM_RW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_req,
  input  logic               stop_req,
  input  logic               wake_evt,
  input  logic               osc_stable,
  input  logic               pll_wait_off,
  input  logic               pstop_sel,
  input  logic               cmon_en,
  input  logic               self_en,
  input  logic               clk_lost,
  input  logic               qual_ok,
  input  logic [WDOG_RW-1:0] wdog_rate,
  input  logic [PTIM_RW-1:0] ptim_rate,
  input  logic               wdog_stop_en,
  input  logic               ptim_stop_en,
  output logic               osc_en,
  output logic               pll_en,
  output logic               sys_clk_en,
  output logic               core_clk_en,
  output logic               wdog_run,
  output logic               ptim_run,
  output logic               self_clk_active,
  output logic               qual_chk_en,
  output logic               loc_rst_req
);

  localparam int WPAD = 16 - WDOG_RW;
  localparam int PPAD = 16 - PTIM_RW;

  pm_mode_t mode, nxt;
  pm_out_t  dec;
  logic     loss_seen;     // monitor saw a lost clock this cycle
  logic     loss_seen_q;
  logic     loss_first;    // first cycle of a loss episode
  logic     self_go;       // named event: Self Clock entry condition
  logic     wdog_on, ptim_on;

  assign loss_seen  = cmon_en & clk_lost;
  assign loss_first = loss_seen & ~loss_seen_q;
  assign self_go    = loss_seen & self_en;
  assign wdog_on    = rate_active({{WPAD{1'b0}}, wdog_rate});
  assign ptim_on    = rate_active({{PPAD{1'b0}}, ptim_rate});

  clkpm_next u_next (
    .mode       (mode),
    .wait_req   (wait_req),
    .stop_req   (stop_req),
    .wake_evt   (wake_evt),
    .osc_stable (osc_stable),
    .pstop_sel  (pstop_sel),
    .self_go    (self_go),
    .qual_ok    (qual_ok),
    .nxt        (nxt)
  );

  clkpm_decode u_dec (
    .mode         (mode),
    .pll_wait_off (pll_wait_off),
    .wdog_on      (wdog_on),
    .ptim_on      (ptim_on),
    .wdog_stop_en (wdog_stop_en),
    .ptim_stop_en (ptim_stop_en),
    .o            (dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= M_RUN;
      loss_seen_q <= 1'b0;
      loc_rst_req <= 1'b0;
    end else begin
      mode        <= nxt;
      loss_seen_q <= loss_seen;
      loc_rst_req <= loss_first & ~self_en & (mode != M_SELF);
    end
  end

  assign osc_en          = dec.osc;
  assign pll_en          = dec.pll;
  assign sys_clk_en      = dec.sys;
  assign core_clk_en     = dec.core;
  assign wdog_run        = dec.wdog;
  assign ptim_run        = dec.ptim;
  assign self_clk_active = dec.self_act;
  assign qual_chk_en     = dec.qchk;

endmodule

// File: rtl/clkpm_ctrl_chk.sv
module clkpm_ctrl_chk #(
  parameter int WDOG_RW = 3,
  parameter int PTIM_RW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmon_en,
  input logic               self_en,
  input logic               clk_lost,
  input logic               qual_ok,
  input logic [WDOG_RW-1:0] wdog_rate,
  input logic [PTIM_RW-1:0] ptim_rate,
  input logic               osc_en,
  input logic               pll_en,
  input logic               sys_clk_en,
  input logic               core_clk_en,
  input logic               wdog_run,
  input logic               ptim_run,
  input logic               self_clk_active,
  input logic               loc_rst_req
);

  AST_OSC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !(sys_clk_en | core_clk_en | pll_en | wdog_run | ptim_run)); // R4

  AST_SELF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_clk_active) |-> $past(cmon_en & self_en & clk_lost)); // R6

  AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    self_clk_active && !qual_ok |=> self_clk_active); // R7

  AST_SELF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    self_clk_active && qual_ok |=> !self_clk_active && pll_en); // R8

  AST_LOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rst_req |=> !loc_rst_req); // R9

  AST_TIMER_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_run |-> wdog_rate != '0) and (ptim_run |-> ptim_rate != '0)); // R1

endmodule

bind clkpm_ctrl clkpm_ctrl_chk #(.WDOG_RW(WDOG_RW), .PTIM_RW(PTIM_RW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmon_en         (cmon_en),
  .self_en         (self_en),
  .clk_lost        (clk_lost),
  .qual_ok         (qual_ok),
  .wdog_rate       (wdog_rate),
  .ptim_rate       (ptim_rate),
  .osc_en          (osc_en),
  .pll_en          (pll_en),
  .sys_clk_en      (sys_clk_en),
  .core_clk_en     (core_clk_en),
  .wdog_run        (wdog_run),
  .ptim_run        (ptim_run),
  .self_clk_active (self_clk_active),
  .loc_rst_req     (loc_rst_req)
);

// File: tb/clkpm_ctrl_tb.sv
`timescale 1ns/1ps
module clkpm_ctrl_tb;

  localparam int WR = 3;
  localparam int PR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, wake_evt = 0, osc_stable = 0;
  logic pll_wait_off = 0, pstop_sel = 0, cmon_en = 0, self_en = 0;
  logic clk_lost = 0, qual_ok = 0, wdog_stop_en = 0, ptim_stop_en = 0;
  logic [WR-1:0] wdog_rate = '0;
  logic [PR-1:0] ptim_rate = '0;
  logic osc_en, pll_en, sys_clk_en, core_clk_en, wdog_run, ptim_run;
  logic self_clk_active, qual_chk_en, loc_rst_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clkpm_ctrl #(.WDOG_RW(WR), .PTIM_RW(PR)) u_dut (.*);

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // Packed outputs: osc pll sys core wdog ptim self qchk
  task automatic chk_all(input string req, input logic [7:0] exp);
    logic [7:0] got;
    got = {osc_en, pll_en, sys_clk_en, core_clk_en, wdog_run, ptim_run,
           self_clk_active, qual_chk_en};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state, rates zero
    chk_all("R1 reset", 8'b1111_0000);
    chk("R1 reset loc", loc_rst_req, 1'b0);

    // R1 sweep of every rate value in Run
    for (int w = 0; w < 8; w++) begin
      for (int p = 0; p < 16; p++) begin
        wdog_rate = w[WR-1:0];
        ptim_rate = p[PR-1:0];
        #1;
        chk("R1 wdog rate", wdog_run, w != 0);
        chk("R1 ptim rate", ptim_run, p != 0);
      end
    end
    wdog_rate = 3'd2; ptim_rate = 4'd9;

    // R2 wait, both PLL settings; R10 wake
    for (int k = 0; k < 2; k++) begin
      pll_wait_off = k[0];
      wait_req = 1; tick(); wait_req = 0;
      chk_all("R2 wait outputs", {1'b1, ~k[0], 6'b1_0_1_1_0_0});
      tick();
      chk("R2 wait holds", core_clk_en, 1'b0);
      wake_evt = 1; tick(); wake_evt = 0;
      chk_all("R10 wait wake", 8'b1111_1100);
    end

    // R3 stop beats wait; R4 full stop; R10 wait for stable
    pstop_sel = 0; osc_stable = 0;
    stop_req = 1; wait_req = 1; tick(); stop_req = 0; wait_req = 0;
    chk_all("R3 R4 full stop", 8'b0000_0000);
    wake_evt = 1; tick(); wake_evt = 0;
    chk_all("R10 fwake gated", 8'b1000_0000);
    tick(); tick();
    chk_all("R10 fwake holds", 8'b1000_0000);
    osc_stable = 1; tick(); osc_stable = 0;
    chk_all("R10 fwake to run", 8'b1111_1100);

    // R5 pseudo stop, every enable combination
    pstop_sel = 1;
    for (int e = 0; e < 4; e++) begin
      wdog_stop_en = e[0]; ptim_stop_en = e[1];
      stop_req = 1; tick(); stop_req = 0;
      chk_all("R3 R5 pseudo stop", {4'b1000, e[0], e[1], 2'b00});
      wake_evt = 1; tick(); wake_evt = 0;
      chk_all("R10 pstop wake", 8'b1111_1100);
    end
    wdog_rate = '0; wdog_stop_en = 1; stop_req = 1; tick(); stop_req = 0;
    chk("R5 zero rate frozen", wdog_run, 1'b0);
    wake_evt = 1; tick(); wake_evt = 0; wdog_rate = 3'd2;

    // R6 entry gating
    cmon_en = 0; self_en = 1; clk_lost = 1; tick();
    chk("R6 monitor off", self_clk_active, 1'b0);
    chk("R9 monitor off no reset", loc_rst_req, 1'b0);
    clk_lost = 0; tick();

    // R9 reset pulse when self clock disabled
    cmon_en = 1; self_en = 0; clk_lost = 1; tick();
    chk("R9 pulse", loc_rst_req, 1'b1);
    chk("R6 no self", self_clk_active, 1'b0);
    tick();
    chk("R9 single cycle", loc_rst_req, 1'b0);
    tick();
    chk("R9 no repeat", loc_rst_req, 1'b0);
    clk_lost = 0; tick();

    // R6 R7 entry, R11 requests ignored
    self_en = 1; clk_lost = 1; tick();
    chk_all("R6 R7 self entry", 8'b1011_1111);
    chk("R9 no reset with self", loc_rst_req, 1'b0);
    stop_req = 1; wait_req = 1; pstop_sel = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_all("R7 R11 self holds", 8'b1011_1111);
    end
    stop_req = 0; wait_req = 0; clk_lost = 0; qual_ok = 1; tick(); qual_ok = 0;
    chk_all("R8 exit to run", 8'b1111_1100);
    tick();
    chk_all("R11 request dropped", 8'b1111_1100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule